// File: doc/BRIEF.md
# SMBus Byte FIFO Pair with Thresholds

This block places a transmit byte queue and a receive byte queue between a host register port and an SMBus byte engine. With it the host can hand over, or collect, several bytes per interrupt instead of one. The host pushes outgoing bytes and pops incoming ones. The engine pops outgoing bytes and pushes incoming ones. Each queue is sixteen entries deep by default.

The host configures the block through a small byte-wide write port with a 3-bit register select. The select values are: 0 = mode, 1 = clear/status, 2 = transmit control, 3 = receive control, 4 = transmit status, 5 = receive status. Three readback buses always show the clear/status, transmit status and receive status bytes. Each queue has a programmable threshold and a sticky threshold flag. A shared sticky flag reports that the transmit queue has drained or that the receive queue has filled. Each flag can raise the interrupt output when its own enable bit is set.

The receive side also drives a "final byte" hint to the engine, so that the engine NACKs the last byte of a transfer. It also gates the data-ready indication according to its interrupt enable.

Top module: `smb_byte_fifo`

## Requirements
- R1: While mode register bit 4 is 0, every push and pop from the host or the engine is ignored and both counts hold. In that state `irq`, `data_ready`, `eng_tx_avail` and `eng_rx_nack` are 0. Reset leaves the block in this state, with all readback buses at 0.
- R2: Both queues are first-in first-out. `eng_tx_data` shows the oldest transmit byte and `host_rx_data` shows the oldest receive byte.
- R3: A push to a full queue or a pop from an empty queue is ignored and leaves the count unchanged. If a full queue sees a push and a pop in the same cycle, only the pop is taken.
- R4: Writing 1 to bit 6 of clear/status empties both queues and zeroes all three flags within one cycle. Bit 6 always reads 0, so both status bytes read 0 afterwards.
- R5: Transmit status has the count in bits 4:0 and the flag in bit 6. The flag is set when an accepted engine pop leaves the count at or below the threshold in transmit control bits 4:0. It stays set until 1 is written to transmit status bit 6.
- R6: Receive status has the count in bits 4:0 and the flag in bit 6. The flag is set when an accepted engine push leaves the count at or above the threshold in receive control bits 4:0. It stays set until 1 is written to receive status bit 6.
- R7: `eng_rx_nack` is 1 exactly when receive control bit 5 is set and the next byte received would bring the count up to the receive threshold.
- R8: When receive control bit 6 is 0, `data_ready` is 1 whenever the receive count is nonzero. When bit 6 is 1, `data_ready` is 1 only when the receive queue is full.
- R9: Clear/status bit 1 is set when an engine pop empties the transmit queue or an engine push fills the receive queue. Writing 1 to bit 1 clears it. Bit 3 is a stored enable that reads back as written.
- R10: `irq` is the OR of three terms: transmit flag AND transmit control bit 6, receive flag AND receive control bit 6, and shared flag AND clear/status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 mode, 1 clear/status, 2 tx ctrl, 3 rx ctrl, 4 tx status, 5 rx status) |
| reg_wdata | input | 8 | Register write data |
| cts_rd | output | 8 | Clear/status readback |
| txs_rd | output | 8 | Transmit status readback |
| rxs_rd | output | 8 | Receive status readback |
| host_tx_push | input | 1 | Host writes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_pop | input | 1 | Host consumes the oldest received byte |
| host_rx_data | output | 8 | Oldest received byte |
| eng_tx_pop | input | 1 | Engine consumes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_avail | output | 1 | Transmit byte available to the engine |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Byte delivered by the engine |
| eng_rx_nack | output | 1 | Next received byte is the final one; engine NACKs it |
| data_ready | output | 1 | Received data ready for the host |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a depth of 16 and 5-bit thresholds. At that size every threshold value from 0 to 16 can be swept on both queues, and every fill level from empty to full is visited in each sweep. Each sweep checks the count, flag, byte order and final-byte hint after every push and pop. Overflow, underflow, simultaneous push/pop at full, the disabled state and every interrupt source are then each exercised against values worked out arithmetically.

// File: rtl/sbf_pkg.sv
// Shared register selects and field positions for the SMBus byte FIFO pair.
// Assumes an 8-bit register data path; field positions are fixed.
package sbf_pkg;

    typedef enum logic [2:0] {
        SEL_MODE    = 3'd0,
        SEL_CLRSTAT = 3'd1,
        SEL_TXCTL   = 3'd2,
        SEL_RXCTL   = 3'd3,
        SEL_TXSTAT  = 3'd4,
        SEL_RXSTAT  = 3'd5
    } reg_sel_e;

    localparam int REG_W        = 8;
    localparam int THR_W        = 5;
    localparam int MODE_EN_BIT  = 4;
    localparam int CS_CLR_BIT   = 6;
    localparam int CS_IE_BIT    = 3;
    localparam int CS_FLAG_BIT  = 1;
    localparam int CTL_IE_BIT   = 6;
    localparam int RXC_LAST_BIT = 5;
    localparam int ST_FLAG_BIT  = 6;

endpackage

// File: rtl/sbf_ring.sv
// Circular byte queue with occupancy count.
// Pushes to a full queue and pops from an empty queue are dropped, judged on
// the state before the edge. A clear empties the queue and wins over both.
module sbf_ring #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [DATA_W-1:0]             push_data,
    input  logic                          pop,
    output logic [DATA_W-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          push_ok,
    output logic                          pop_ok
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (count != CNT_W'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign head    = mem[rp];

    // Store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wp] <= push_data;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= nxt(wp);
            if (pop_ok)  rp <= nxt(rp);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    a_r3_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && push && !pop && !clr) |=> count == CNT_W'(DEPTH));

    a_r3_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push && !clr) |=> count == '0);

    a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);

endmodule

// File: rtl/sbf_ctrl.sv
// Configuration registers, sticky threshold/drain flags, data-ready gating,
// final-byte hint and interrupt combine for the byte FIFO pair.
// Assumes the queues report accepted push/pop strobes and their counts.
module sbf_ctrl
    import sbf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [2:0]                   reg_sel,
    input  logic [REG_W-1:0]             reg_wdata,
    input  logic [$clog2(DEPTH+1)-1:0]   tx_count,
    input  logic [$clog2(DEPTH+1)-1:0]   rx_count,
    input  logic                         tx_push_ok,
    input  logic                         tx_pop_ok,
    input  logic                         rx_push_ok,
    input  logic                         rx_pop_ok,
    output logic                         fifo_en,
    output logic                         clr,
    output logic [REG_W-1:0]             cts_rd,
    output logic [REG_W-1:0]             txs_rd,
    output logic [REG_W-1:0]             rxs_rd,
    output logic                         eng_rx_nack,
    output logic                         data_ready,
    output logic                         irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CW    = (CNT_W + 1 > THR_W + 1) ? CNT_W + 1 : THR_W + 1;

    logic             cs_ie, tx_ie, rx_ie, rx_last;
    logic [THR_W-1:0] tx_thr, rx_thr;
    logic             tx_flag, rx_flag, both_flag;
    logic             wr_mode, wr_cs, wr_txc, wr_rxc, wr_txs, wr_rxs;
    logic [CW-1:0]    tx_next, rx_next;
    logic             tx_set, rx_set, both_set;

    assign wr_mode = reg_wr && (reg_sel == SEL_MODE);
    assign wr_cs   = reg_wr && (reg_sel == SEL_CLRSTAT);
    assign wr_txc  = reg_wr && (reg_sel == SEL_TXCTL);
    assign wr_rxc  = reg_wr && (reg_sel == SEL_RXCTL);
    assign wr_txs  = reg_wr && (reg_sel == SEL_TXSTAT);
    assign wr_rxs  = reg_wr && (reg_sel == SEL_RXSTAT);
    assign clr     = wr_cs && reg_wdata[CS_CLR_BIT];

    // Occupancy after this edge, used to judge the flag events.
    assign tx_next = CW'(tx_count) + CW'(tx_push_ok) - CW'(tx_pop_ok);
    assign rx_next = CW'(rx_count) + CW'(rx_push_ok) - CW'(rx_pop_ok);

    assign tx_set   = tx_pop_ok && (tx_next <= CW'(tx_thr));
    assign rx_set   = rx_push_ok && (rx_next >= CW'(rx_thr));
    assign both_set = (tx_pop_ok && tx_next == '0) ||
                      (rx_push_ok && rx_next == CW'(DEPTH));

    // Hold the configuration fields written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            cs_ie   <= 1'b0;
            tx_ie   <= 1'b0;
            tx_thr  <= '0;
            rx_ie   <= 1'b0;
            rx_last <= 1'b0;
            rx_thr  <= '0;
        end else begin
            if (wr_mode) fifo_en <= reg_wdata[MODE_EN_BIT];
            if (wr_cs)   cs_ie   <= reg_wdata[CS_IE_BIT];
            if (wr_txc) begin
                tx_ie  <= reg_wdata[CTL_IE_BIT];
                tx_thr <= reg_wdata[THR_W-1:0];
            end
            if (wr_rxc) begin
                rx_ie   <= reg_wdata[CTL_IE_BIT];
                rx_last <= reg_wdata[RXC_LAST_BIT];
                rx_thr  <= reg_wdata[THR_W-1:0];
            end
        end
    end

    // Sticky flags: set by events, cleared by write-one or the queue clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tx_flag   <= 1'b0;
            rx_flag   <= 1'b0;
            both_flag <= 1'b0;
        end else begin
            tx_flag   <= tx_set   || (tx_flag && !(wr_txs && reg_wdata[ST_FLAG_BIT]));
            rx_flag   <= rx_set   || (rx_flag && !(wr_rxs && reg_wdata[ST_FLAG_BIT]));
            both_flag <= both_set || (both_flag && !(wr_cs && reg_wdata[CS_FLAG_BIT]));
        end
    end

    // Assemble the readback bytes.
    always_comb begin
        cts_rd = '0;
        cts_rd[CS_IE_BIT]   = cs_ie;
        cts_rd[CS_FLAG_BIT] = both_flag;
        txs_rd = '0;
        txs_rd[THR_W-1:0]   = THR_W'(tx_count);
        txs_rd[ST_FLAG_BIT] = tx_flag;
        rxs_rd = '0;
        rxs_rd[THR_W-1:0]   = THR_W'(rx_count);
        rxs_rd[ST_FLAG_BIT] = rx_flag;
    end

    // Engine hint, host data-ready and interrupt combine.
    assign eng_rx_nack = fifo_en && rx_last && ((CW'(rx_count) + CW'(1)) == CW'(rx_thr));
    assign data_ready  = fifo_en && (rx_ie ? (rx_count == CNT_W'(DEPTH)) : (rx_count != '0));
    assign irq         = fifo_en && ((tx_flag && tx_ie) || (rx_flag && rx_ie) ||
                                     (both_flag && cs_ie));

    a_r4_clear_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!tx_flag && !rx_flag && !both_flag));

    a_r9_shared_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cs && reg_wdata[CS_FLAG_BIT] && !both_set) |=> !both_flag);

    a_r5_tx_flag_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txs && reg_wdata[ST_FLAG_BIT] && !tx_set) |=> !tx_flag);

    a_r6_rx_flag_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rxs && reg_wdata[ST_FLAG_BIT] && !rx_set) |=> !rx_flag);

endmodule

// File: rtl/smb_byte_fifo.sv
// Top of the SMBus byte FIFO pair: transmit queue (host in, engine out),
// receive queue (engine in, host out) and their control.
// Assumes the host and engine only push/pop while the mode bit is set;
// anything else is dropped here.
module smb_byte_fifo
    import sbf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  cts_rd,
    output logic [REG_W-1:0]  txs_rd,
    output logic [REG_W-1:0]  rxs_rd,
    input  logic              host_tx_push,
    input  logic [DATA_W-1:0] host_tx_data,
    input  logic              host_rx_pop,
    output logic [DATA_W-1:0] host_rx_data,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              eng_rx_nack,
    output logic              data_ready,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             fifo_en, clr;
    logic [CNT_W-1:0] tx_count, rx_count;
    logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;

    sbf_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (host_tx_push && fifo_en),
        .push_data (host_tx_data),
        .pop       (eng_tx_pop && fifo_en),
        .head      (eng_tx_data),
        .count     (tx_count),
        .push_ok   (tx_push_ok),
        .pop_ok    (tx_pop_ok)
    );

    sbf_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (eng_rx_push && fifo_en),
        .push_data (eng_rx_data),
        .pop       (host_rx_pop && fifo_en),
        .head      (host_rx_data),
        .count     (rx_count),
        .push_ok   (rx_push_ok),
        .pop_ok    (rx_pop_ok)
    );

    sbf_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .tx_count    (tx_count),
        .rx_count    (rx_count),
        .tx_push_ok  (tx_push_ok),
        .tx_pop_ok   (tx_pop_ok),
        .rx_push_ok  (rx_push_ok),
        .rx_pop_ok   (rx_pop_ok),
        .fifo_en     (fifo_en),
        .clr         (clr),
        .cts_rd      (cts_rd),
        .txs_rd      (txs_rd),
        .rxs_rd      (rxs_rd),
        .eng_rx_nack (eng_rx_nack),
        .data_ready  (data_ready),
        .irq         (irq)
    );

    assign eng_tx_avail = fifo_en && (tx_count != '0);

    a_r1_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !clr) |=> ($stable(tx_count) && $stable(rx_count)));

    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (!irq && !data_ready && !eng_tx_avail && !eng_rx_nack));

endmodule

// File: tb/test_smb_byte_fifo.sv
// Self-checking bench: threshold sweeps on both queues at the default size.
module test_smb_byte_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] cts_rd, txs_rd, rxs_rd;
    logic       host_tx_push = 1'b0;
    logic [7:0] host_tx_data = '0;
    logic       host_rx_pop = 1'b0;
    logic [7:0] host_rx_data;
    logic       eng_tx_pop = 1'b0;
    logic [7:0] eng_tx_data;
    logic       eng_tx_avail;
    logic       eng_rx_push = 1'b0;
    logic [7:0] eng_rx_data = '0;
    logic       eng_rx_nack, data_ready, irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    smb_byte_fifo i_smb_byte_fifo (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cts_rd(cts_rd), .txs_rd(txs_rd), .rxs_rd(rxs_rd),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_avail(eng_tx_avail), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_rx_nack(eng_rx_nack),
        .data_ready(data_ready), .irq(irq)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        tick;
        reg_wr = 1'b0;
    endtask

    task automatic tx_push(input logic [7:0] d);
        host_tx_push = 1'b1; host_tx_data = d;
        tick;
        host_tx_push = 1'b0;
    endtask

    task automatic tx_pop;
        eng_tx_pop = 1'b1;
        tick;
        eng_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d;
        tick;
        eng_rx_push = 1'b0;
    endtask

    task automatic rx_pop;
        host_rx_pop = 1'b1;
        tick;
        host_rx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // R1: reset state, then pushes ignored while the mode bit is 0
        chk("R1 reset cts", int'(cts_rd), 0);
        chk("R1 reset txs", int'(txs_rd), 0);
        chk("R1 reset rxs", int'(rxs_rd), 0);
        chk("R1 reset outs", int'({irq, data_ready, eng_tx_avail, eng_rx_nack}), 0);
        tx_push(8'h55);
        rx_push(8'h66);
        chk("R1 off tx push", int'(txs_rd), 0);
        chk("R1 off rx push", int'(rxs_rd), 0);
        wr(3'd0, 8'h10);

        // R2 R3 R5 R9: transmit threshold sweep
        for (int thr = 0; thr <= 16; thr++) begin
            wr(3'd1, 8'h40);
            chk("R4 clear txs", int'(txs_rd), 0);
            wr(3'd2, 8'(thr));
            for (int i = 0; i < 16; i++) begin
                tx_push(8'((thr * 7 + i * 13) & 255));
                chk("R5 tx fill count", int'(txs_rd), i + 1);
            end
            tx_push(8'hEE);
            chk("R3 tx push at full", int'(txs_rd), 16);
            for (int k = 1; k <= 16; k++) begin
                chk("R2 tx order", int'(eng_tx_data), (thr * 7 + (k - 1) * 13) & 255);
                chk("R2 tx avail", int'(eng_tx_avail), 1);
                tx_pop;
                chk("R5 tx drain status", int'(txs_rd),
                    (((16 - k) <= thr) ? 64 : 0) + (16 - k));
            end
            tx_pop;
            chk("R3 tx pop at empty", int'(txs_rd), 64);
            chk("R2 tx avail empty", int'(eng_tx_avail), 0);
            chk("R9 drained flag", int'(cts_rd), 2);
        end

        // R10 R9 R5: interrupt sources on the transmit side
        chk("R10 no enables", int'(irq), 0);
        wr(3'd1, 8'h08);
        chk("R9 ie stored", int'(cts_rd), 8'h0A);
        chk("R10 shared irq", int'(irq), 1);
        wr(3'd1, 8'h0A);
        chk("R9 w1c", int'(cts_rd), 8'h08);
        chk("R10 shared cleared", int'(irq), 0);
        wr(3'd2, 8'h40);
        chk("R10 tx irq", int'(irq), 1);
        wr(3'd4, 8'h40);
        chk("R5 tx w1c", int'(txs_rd), 0);
        chk("R10 tx irq cleared", int'(irq), 0);

        // R2 R3 R6 R7 R8 R9: receive threshold sweep with the last flag set
        for (int thr = 0; thr <= 16; thr++) begin
            wr(3'd1, 8'h40);
            chk("R4 clear rxs", int'(rxs_rd), 0);
            wr(3'd3, 8'(32 + thr));
            for (int k = 0; k < 16; k++) begin
                chk("R7 nack hint", int'(eng_rx_nack), (k + 1 == thr) ? 1 : 0);
                rx_push(8'((thr * 11 + k * 5 + 3) & 255));
                chk("R6 rx fill status", int'(rxs_rd),
                    (((k + 1) >= thr) ? 64 : 0) + (k + 1));
                chk("R8 ready no ie", int'(data_ready), 1);
            end
            rx_push(8'hEE);
            chk("R3 rx push at full", int'(rxs_rd), 64 + 16);
            chk("R9 full flag", int'(cts_rd), 2);
            for (int k = 0; k < 16; k++) begin
                chk("R2 rx order", int'(host_rx_data), (thr * 11 + k * 5 + 3) & 255);
                rx_pop;
                chk("R6 rx drain count", int'(rxs_rd), 64 + 15 - k);
            end
            rx_pop;
            chk("R3 rx pop at empty", int'(rxs_rd), 64);
            chk("R8 ready empty", int'(data_ready), 0);
        end

        // R8 R10: data-ready held back until full when rx ie is set
        wr(3'd1, 8'h40);
        wr(3'd3, 8'h44);
        for (int k = 1; k <= 15; k++) begin
            rx_push(8'(k));
            chk("R8 ready held", int'(data_ready), 0);
        end
        chk("R10 rx irq", int'(irq), 1);
        rx_push(8'h10);
        chk("R8 ready at full", int'(data_ready), 1);
        wr(3'd5, 8'h40);
        chk("R6 rx w1c", int'(rxs_rd), 16);
        chk("R10 rx irq cleared", int'(irq), 0);

        // R3: push and pop together on a full receive queue
        eng_rx_push = 1'b1; host_rx_pop = 1'b1; eng_rx_data = 8'hAB;
        tick;
        eng_rx_push = 1'b0; host_rx_pop = 1'b0;
        chk("R3 full push+pop", int'(rxs_rd), 15);
        chk("R2 rx head after", int'(host_rx_data), 2);

        // R1: mode bit cleared freezes both queues
        wr(3'd0, 8'h00);
        tx_push(8'h77);
        rx_push(8'h78);
        rx_pop;
        chk("R1 off txs", int'(txs_rd), 0);
        chk("R1 off rxs", int'(rxs_rd), 15);
        chk("R1 off outputs", int'({irq, data_ready, eng_tx_avail, eng_rx_nack}), 0);
        wr(3'd0, 8'h10);
        rx_pop;
        chk("R1 re-enabled pop", int'(rxs_rd), 14);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule